// File: doc/BRIEF.md
# Dual-Edge Interleaved Word Memory

This block is a behavioural synchronous memory of 128 words, each 64 bits wide. It is split by address parity into two banks of 64 words. The even bank serves requests on the rising clock edge and the odd bank serves them on the falling edge. Each bank is idle in the half period in which the other one works, and that idle half period stands in for the precharge phase. A caller that alternates even and odd addresses on every half period moves two words per clock period through one request port.

The request port carries an enable, a write strobe, a 7-bit word address and 64 bits of write data. It is sampled on both edges. A request sampled on a rising edge must use an even address, and one sampled on a falling edge must use an odd address. A request with the wrong parity is dropped and raises the error flag of the side whose edge sampled it. Each side has its own registered read-data bus and valid strobe. Results appear half a clock period after the sampling edge and stay steady for one full period, so the consumer can capture them on the edge that follows.

Top module: `ddr_sram`

## Requirements
- R1: A word written at address A is returned by any later read of A. Address bit 0 picks the bank (0 = even bank, 1 = odd bank), and bits 6:1 pick the row inside the bank, which gives 128 distinct 64-bit words.
- R2: An even-address request is sampled on the rising clock edge, and an even-address write is stored at that edge.
- R3: An odd-address request is sampled on the falling clock edge, and an odd-address write is stored at that edge.
- R4: An accepted rising-edge request drives `even_rvalid` high with its data on `even_rdata` from the next falling edge until the falling edge after that.
- R5: An accepted falling-edge request drives `odd_rvalid` high with its data on `odd_rdata` from the next rising edge until the rising edge after that.
- R6: A request whose address bit 0 does not match its edge (1 on a rising edge, 0 on a falling edge) changes no stored word and produces no valid strobe. It sets `even_perr` (rising edge) or `odd_perr` (falling edge) from that edge until the same edge one period later.
- R7: An accepted write also returns, with its valid strobe, the word that was stored at its address before the write (read-before-write).
- R8: An edge with `acc_en` low changes no stored word, and afterwards the valid strobe and the error flag of that side are low.
- R9: While `rst` is high at an edge, that edge performs no access and clears the valid and error outputs it owns. Stored words are not initialised and are left untouched by reset.
- R10: Requests on every half period that alternate between even and odd addresses are all performed, which gives two words per clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are active |
| rst | input | 1 | Synchronous active-high reset, sampled on both edges |
| acc_en | input | 1 | Request present on this edge |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 7 | Word address; bit 0 must match the edge |
| acc_wdata | input | 64 | Data to store on a write |
| even_rdata | output | 64 | Result of the last accepted rising-edge request |
| even_rvalid | output | 1 | `even_rdata` holds a fresh result |
| even_perr | output | 1 | The last rising-edge request had an odd address |
| odd_rdata | output | 64 | Result of the last accepted falling-edge request |
| odd_rvalid | output | 1 | `odd_rdata` holds a fresh result |
| odd_perr | output | 1 | The last falling-edge request had an even address |

## Verification
The assertions assume that every request input is stable around both clock edges, because each bank samples the same port on its own edge, and that `rst` is synchronous to both edges. The bench meets this by changing inputs only a quarter period before each edge, never near one. It gives every half period its own request, so one stream exercises both banks, both sampling edges and their interleaving.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;

    // Which clock edge a bank works on; the value equals the address parity it owns.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    function automatic edge_e other_edge(edge_e s);
        return (s == EDGE_RISE) ? EDGE_FALL : EDGE_RISE;
    endfunction

    // True when the address parity bit belongs to the bank on edge s.
    function automatic logic parity_ok(edge_e s, logic lsb);
        return lsb == logic'(s);
    endfunction

endpackage

// File: rtl/ddr_sram_bank.sv
module ddr_sram_bank
    import ddr_sram_pkg::*;
#(
    parameter int unsigned DW   = 64,
    parameter int unsigned ROWS = 64,
    parameter edge_e       SIDE = EDGE_RISE,
    localparam int unsigned RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic          lsb,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q_data,
    output logic          q_vld,
    output logic          q_err
);

    typedef struct packed {
        logic hit;
        logic wr;
        logic miss;
    } decode_t;

    logic [DW-1:0] mem [ROWS];
    decode_t       dec;

    always_comb begin
        dec.hit  = en && parity_ok(SIDE, lsb);
        dec.wr   = dec.hit && we;
        dec.miss = en && !parity_ok(SIDE, lsb);
    end

    generate
        if (SIDE == EDGE_RISE) begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_vld <= 1'b0;
                    q_err <= 1'b0;
                end else begin
                    q_vld <= dec.hit;
                    q_err <= dec.miss;
                    if (dec.hit) q_data <= mem[row];
                    if (dec.wr)  mem[row] <= wdata;
                end
            end

            AST_RISE_MISS_FLAG: assert property (@(posedge clk) disable iff (rst)
                (en && !lsb == 1'b0 && lsb) |=> (q_err && !q_vld)); // R6
            AST_RISE_HIT_VALID: assert property (@(posedge clk) disable iff (rst)
                (en && !lsb) |=> (q_vld && !q_err)); // R2
            AST_RISE_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
                !en |=> (!q_vld && !q_err)); // R8
        end else begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) begin
                    q_vld <= 1'b0;
                    q_err <= 1'b0;
                end else begin
                    q_vld <= dec.hit;
                    q_err <= dec.miss;
                    if (dec.hit) q_data <= mem[row];
                    if (dec.wr)  mem[row] <= wdata;
                end
            end

            AST_FALL_MISS_FLAG: assert property (@(negedge clk) disable iff (rst)
                (en && !lsb) |=> (q_err && !q_vld)); // R6
            AST_FALL_HIT_VALID: assert property (@(negedge clk) disable iff (rst)
                (en && lsb) |=> (q_vld && !q_err)); // R3
            AST_FALL_IDLE_QUIET: assert property (@(negedge clk) disable iff (rst)
                !en |=> (!q_vld && !q_err)); // R8
        end
    endgenerate

endmodule

// File: rtl/ddr_sram_half_stage.sv
module ddr_sram_half_stage
    import ddr_sram_pkg::*;
#(
    parameter int unsigned DW      = 64,
    parameter edge_e       CAPTURE = EDGE_FALL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] in_data,
    input  logic          in_vld,
    output logic [DW-1:0] out_data,
    output logic          out_vld
);

    generate
        if (CAPTURE == EDGE_RISE) begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_vld <= 1'b0;
                end else begin
                    out_vld <= in_vld;
                    if (in_vld) out_data <= in_data;
                end
            end

            AST_RISE_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> ($stable(out_data) && !out_vld)); // R5
        end else begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) begin
                    out_vld <= 1'b0;
                end else begin
                    out_vld <= in_vld;
                    if (in_vld) out_data <= in_data;
                end
            end

            AST_FALL_DATA_HOLD: assert property (@(negedge clk) disable iff (rst)
                !in_vld |=> ($stable(out_data) && !out_vld)); // R4
        end
    endgenerate

endmodule

// File: rtl/ddr_sram.sv
module ddr_sram
    import ddr_sram_pkg::*;
#(
    parameter int unsigned WORDS = 128,
    parameter int unsigned DW    = 64,
    localparam int unsigned AW   = $clog2(WORDS),
    localparam int unsigned ROWS = WORDS / 2,
    localparam int unsigned RW   = AW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_en,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] even_rdata,
    output logic          even_rvalid,
    output logic          even_perr,
    output logic [DW-1:0] odd_rdata,
    output logic          odd_rvalid,
    output logic          odd_perr
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
        logic          err;
    } side_t;

    side_t bank_q [2];
    side_t side_o [2];

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_side
            localparam edge_e S = edge_e'(g);

            ddr_sram_bank #(
                .DW   (DW),
                .ROWS (ROWS),
                .SIDE (S)
            ) i_bank (
                .clk    (clk),
                .rst    (rst),
                .en     (acc_en),
                .we     (acc_we),
                .lsb    (acc_addr[0]),
                .row    (acc_addr[AW-1:1]),
                .wdata  (acc_wdata),
                .q_data (bank_q[g].data),
                .q_vld  (bank_q[g].vld),
                .q_err  (bank_q[g].err)
            );

            ddr_sram_half_stage #(
                .DW      (DW),
                .CAPTURE (other_edge(S))
            ) i_stage (
                .clk      (clk),
                .rst      (rst),
                .in_data  (bank_q[g].data),
                .in_vld   (bank_q[g].vld),
                .out_data (side_o[g].data),
                .out_vld  (side_o[g].vld)
            );

            assign side_o[g].err = bank_q[g].err;
        end
    endgenerate

    assign even_rdata  = side_o[0].data;
    assign even_rvalid = side_o[0].vld;
    assign even_perr   = side_o[0].err;
    assign odd_rdata   = side_o[1].data;
    assign odd_rvalid  = side_o[1].vld;
    assign odd_perr    = side_o[1].err;

    AST_EVEN_VALID_AFTER_HIT: assert property (@(negedge clk) disable iff (rst)
        bank_q[0].vld |=> even_rvalid); // R4
    AST_ODD_VALID_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
        bank_q[1].vld |=> odd_rvalid); // R5

endmodule

// File: tb/test_ddr_sram.sv
module test_ddr_sram;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_en;
    logic        acc_we;
    logic [6:0]  acc_addr;
    logic [63:0] acc_wdata;
    logic [63:0] even_rdata;
    logic        even_rvalid;
    logic        even_perr;
    logic [63:0] odd_rdata;
    logic        odd_rvalid;
    logic        odd_perr;

    always #10 clk = ~clk;

    ddr_sram i_ddr_sram (
        .clk         (clk),
        .rst         (rst),
        .acc_en      (acc_en),
        .acc_we      (acc_we),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .even_rdata  (even_rdata),
        .even_rvalid (even_rvalid),
        .even_perr   (even_perr),
        .odd_rdata   (odd_rdata),
        .odd_rvalid  (odd_rvalid),
        .odd_perr    (odd_perr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int sidx  = 0;
    bit done  = 1'b0;

    logic [63:0] refm  [128];
    bit          known [128];

    // History of the last four half-period slots.
    logic        h_rst [4];
    logic        h_vld [4];
    logic        h_err [4];
    logic        h_dck [4];
    logic [63:0] h_dat [4];
    string       h_tag [4];

    // {en, we, addr[6:0], wdata[63:0]}; entry i lands on a rising edge when i is even.
    localparam logic [72:0] VEC [18] = '{
        {1'b1, 1'b1, 7'd10,  64'h1111_0000_0000_1111},
        {1'b1, 1'b1, 7'd11,  64'h2222_0000_0000_2222},
        {1'b1, 1'b0, 7'd10,  64'h0},
        {1'b1, 1'b0, 7'd11,  64'h0},
        {1'b0, 1'b1, 7'd12,  64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 1'b1, 7'd13,  64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 1'b0, 7'd7,   64'h0},
        {1'b1, 1'b1, 7'd20,  64'hDEAD_BEEF_DEAD_BEEF},
        {1'b1, 1'b0, 7'd20,  64'h0},
        {1'b1, 1'b0, 7'd7,   64'h0},
        {1'b1, 1'b1, 7'd0,   64'h0123_4567_89AB_CDEF},
        {1'b1, 1'b1, 7'd127, 64'hFEDC_BA98_7654_3210},
        {1'b1, 1'b0, 7'd0,   64'h0},
        {1'b1, 1'b0, 7'd127, 64'h0},
        {1'b1, 1'b1, 7'd10,  64'h3333_0000_0000_3333},
        {1'b1, 1'b0, 7'd11,  64'h0},
        {1'b0, 1'b0, 7'd0,   64'h0},
        {1'b0, 1'b0, 7'd0,   64'h0}
    };

    function automatic logic [63:0] pattern(int k);
        return 64'hA5A5_0000_0000_5A5A ^ ({32'd0, 32'(k)} * 64'h0001_0003_0007_000F);
    endfunction

    function automatic string auto_tag(bit e, bit w, bit a0, bit rise);
        if (!e)                return "R8";
        if (a0 != !rise)       return "R6";
        if (w)                 return rise ? "R2" : "R3";
        return rise ? "R4" : "R5";
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One half period: check outputs from earlier slots, drive this slot's request.
    task automatic slot(bit r, bit e, bit w, logic [6:0] a, logic [63:0] d, string tag);
        int  k  = sidx % 4;
        int  p1 = (sidx + 3) % 4;
        int  p2 = (sidx + 2) % 4;
        bit  rise = (sidx % 2) == 0;
        bit  hit;
        bit  ev;
        logic [63:0] ad;
        logic        av;
        logic        ae;
        if (sidx >= 1) begin
            ae = (((sidx - 1) % 2) == 0) ? even_perr : odd_perr;
            chk(ae == h_err[p1], h_tag[p1], "perr", 64'(ae), 64'(h_err[p1]));
        end
        if (sidx >= 2) begin
            ev = h_vld[p2] && !h_rst[p1];
            av = rise ? even_rvalid : odd_rvalid;
            ad = rise ? even_rdata  : odd_rdata;
            chk(av == ev, h_tag[p2], "rvalid", 64'(av), 64'(ev));
            if (ev && h_dck[p2])
                chk(ad === h_dat[p2], h_tag[p2], "rdata", ad, h_dat[p2]);
        end
        rst       = r;
        acc_en    = e;
        acc_we    = w;
        acc_addr  = a;
        acc_wdata = d;
        hit      = !r && e && (a[0] == !rise);
        h_rst[k] = r;
        h_vld[k] = hit;
        h_err[k] = !r && e && !hit;
        h_dck[k] = hit && known[a];
        h_dat[k] = refm[a];
        h_tag[k] = (tag == "") ? auto_tag(e, w, a[0], rise) : tag;
        if (hit && w) begin
            refm[a]  = d;
            known[a] = 1'b1;
        end
        sidx++;
        @(clk);
        #5;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) known[i] = 1'b0;
        rst = 1'b1; acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
        #5;

        // Reset: requests presented under reset do nothing (R9).
        slot(1, 1, 1, 7'd2, 64'h1, "R9");
        slot(1, 1, 0, 7'd3, 64'h0, "R9");
        slot(1, 1, 0, 7'd5, 64'h0, "R9");
        slot(1, 0, 0, 7'd0, 64'h0, "R9");
        chk(even_rvalid == 1'b0, "R9", "even_rvalid in reset", 64'(even_rvalid), 64'd0);
        chk(odd_rvalid  == 1'b0, "R9", "odd_rvalid in reset",  64'(odd_rvalid),  64'd0);
        chk(even_perr   == 1'b0, "R9", "even_perr in reset",   64'(even_perr),   64'd0);
        chk(odd_perr    == 1'b0, "R9", "odd_perr in reset",    64'(odd_perr),    64'd0);
        slot(0, 0, 0, 7'd0, 64'h0, "R9");
        slot(0, 0, 0, 7'd0, 64'h0, "R9");

        // Back-to-back writes on every half period, alternating parity (R10).
        for (int k = 0; k < 128; k++) slot(0, 1, 1, 7'(k), pattern(k), "R10");
        // Read every word back (R1).
        for (int k = 0; k < 128; k++) slot(0, 1, 0, 7'(k), 64'h0, "R1");

        // Vector table: mixed reads, writes, idles and wrong-parity requests.
        for (int i = 0; i < 18; i++)
            slot(0, VEC[i][72], VEC[i][71], VEC[i][70:64], VEC[i][63:0], "");

        // Read-before-write on repeated writes (R7).
        slot(0, 1, 1, 7'd40, 64'h4040_AAAA_0000_0001, "R7");
        slot(0, 1, 1, 7'd41, 64'h4141_BBBB_0000_0001, "R7");
        slot(0, 1, 1, 7'd40, 64'h4040_AAAA_0000_0002, "R7");
        slot(0, 1, 1, 7'd41, 64'h4141_BBBB_0000_0002, "R7");
        slot(0, 1, 0, 7'd40, 64'h0, "R7");
        slot(0, 1, 0, 7'd41, 64'h0, "R7");

        // Wrong-parity writes leave the target word alone (R6).
        slot(0, 1, 1, 7'd41, 64'hBAD0_BAD0_BAD0_BAD0, "R6");
        slot(0, 1, 1, 7'd40, 64'hBAD1_BAD1_BAD1_BAD1, "R6");
        slot(0, 1, 0, 7'd40, 64'h0, "R6");
        slot(0, 1, 0, 7'd41, 64'h0, "R6");

        // Mid-run reset: clears outputs, blocks access, keeps stored words (R9).
        slot(0, 1, 1, 7'd50, 64'h5050_5050_5050_5050, "R9");
        slot(1, 1, 0, 7'd51, 64'h0, "R9");
        slot(1, 1, 1, 7'd52, 64'h5252_0000_0000_5252, "R9");
        slot(0, 0, 0, 7'd0,  64'h0, "R9");
        slot(0, 1, 0, 7'd50, 64'h0, "R9");
        slot(0, 1, 0, 7'd51, 64'h0, "R9");
        slot(0, 1, 0, 7'd52, 64'h0, "R9");

        for (int i = 0; i < 4; i++) slot(0, 0, 0, 7'd0, 64'h0, "R8");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule